// File: doc/BRIEF.md
# Fast-Access Bus Arbitration Controller

This controller sits between a host CPU and a coprocessor that share one ROM interface. It tracks whether the host has switched its ROM accesses to the fast speed grade. When the host then performs a real fast-speed ROM read, the controller holds the coprocessor in a pause and hands the ROM interface to the host until that read has finished. Accesses that the host's speed logic treats as slow never disturb the coprocessor. These are reads in the low half of the bank space, reads made by the DMA engine, and any access while fast mode is off.

The controller learns the speed setting by watching host writes to the speed-control register. It decodes every host cycle from the bank byte, the 16-bit offset, the read and write strobes and the DMA-active flag. The pause is a clean level that covers the whole access, so a coprocessor that stalls on it keeps all of its state and resumes on the instruction where it stopped. ROM timing itself belongs to other logic.

Top module: `fast_rom_arbiter`

## Requirements
- R1: After synchronous reset, fast mode is disabled, `cop_pause` is 0, and `rom_owner` is 2'b01 (coprocessor owns the ROM interface).
- R2: A host write to offset 0x420D in a bank with bank bit 6 clear (banks 0x00-0x3F and 0x80-0xBF) loads fast mode from write-data bit 0. Write-data bits 7:1 have no effect.
- R3: Host writes to any other offset, or to offset 0x420D in banks 0x40-0x7F or 0xC0-0xFF, leave fast mode unchanged.
- R4: With fast mode on, a non-DMA host read in banks 0x80-0xBF at offsets 0x8000-0xFFFF pauses the coprocessor, and `rom_owner` becomes 2'b10 (host owns the interface).
- R5: With fast mode on, a non-DMA host read at any offset in banks 0xC0-0xFF pauses the coprocessor, and `rom_owner` becomes 2'b10.
- R6: Host reads in banks 0x00-0x7F never pause the coprocessor.
- R7: Reads with `host_dma` high never pause the coprocessor, including reads from banks 0x80-0xFF.
- R8: While fast mode is off, no host access pauses the coprocessor.
- R9: The outputs are registered. `cop_pause` rises on the clock edge that samples a qualifying read, stays high while the read is presented, and falls on the first edge that samples the read gone. `rom_owner` is 2'b10 exactly when `cop_pause` is 1 and 2'b01 otherwise.
- R10: Reads in banks 0x80-0xBF at offsets 0x0000-0x7FFF (not ROM) never pause the coprocessor.
- R11: Host writes never pause the coprocessor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_bank | input | 8 | Host address bank byte |
| host_addr | input | 16 | Host address offset within the bank |
| host_rd | input | 1 | Host read strobe, high for the whole access |
| host_wr | input | 1 | Host write strobe |
| host_dma | input | 1 | Current host access is made by the DMA engine |
| host_wdata | input | 8 | Host write data, snooped for the speed register |
| cop_pause | output | 1 | Pause request to the coprocessor |
| rom_owner | output | 2 | One-hot ROM interface owner: 2'b10 host, 2'b01 coprocessor |

## Verification
The embedded assertions check on every cycle that the owner code stays one-hot and agrees with the pause. They also check that DMA reads, low-bank reads and strobe-free cycles are never followed by a pause, that a pause never follows a cycle with fast mode off, and that the mode bit holds across writes that do not hit the register. Only the bench's scenarios can show the positive decisions: a pause in the ROM window of 0x80-0xBF and anywhere in 0xC0-0xFF, the exact rise and fall edges, the rejection of mirror banks and neighbouring offsets by the snoop, and the fact that only bit 0 of the written byte matters.

// File: rtl/fast_rom_arbiter_pkg.sv
package fast_rom_arbiter_pkg;
  // One-hot owner of the shared ROM interface
  typedef enum logic [1:0] {
    OWNER_COP  = 2'b01,
    OWNER_HOST = 2'b10
  } rom_owner_e;
endpackage

// File: rtl/fra_speed_snoop.sv
module fra_speed_snoop #(
  parameter int BANK_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'h420D,
  parameter int ENABLE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              fast_en
);
  // Register is visible only in banks whose bit (BANK_W-2) is clear
  localparam int SYS_BIT = BANK_W - 2;

  logic reg_hit;
  assign reg_hit = wr && (addr == REG_OFFSET) && !bank[SYS_BIT];

  always_ff @(posedge clk) begin
    if (rst)          fast_en <= 1'b0;
    else if (reg_hit) fast_en <= wdata[ENABLE_BIT];
  end

  // R3: mode bit holds across cycles without a register hit
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr && (addr == REG_OFFSET) && !bank[SYS_BIT]) |=> $stable(fast_en));
endmodule

// File: rtl/fra_access_decode.sv
module fra_access_decode #(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              dma,
  output logic              fast_rom_rd
);
  localparam int HI_BIT  = BANK_W - 1;  // upper half of bank space: fast grade
  localparam int MAP_BIT = BANK_W - 2;  // upper quarter: whole bank is ROM
  localparam int WIN_BIT = ADDR_W - 1;  // upper half of offset: ROM window

  logic in_rom;
  assign in_rom      = bank[MAP_BIT] || addr[WIN_BIT];
  assign fast_rom_rd = rd && !dma && bank[HI_BIT] && in_rom;
endmodule

// File: rtl/fast_rom_arbiter.sv
module fast_rom_arbiter
  import fast_rom_arbiter_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SPEED_REG = 16'h420D,
  parameter int SPEED_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] host_bank,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_dma,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              cop_pause,
  output logic [1:0]        rom_owner
);
  logic fast_en;
  logic fast_rom_rd;

  fra_speed_snoop #(
    .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REG_OFFSET(SPEED_REG), .ENABLE_BIT(SPEED_BIT)
  ) u_snoop (
    .clk(clk), .rst(rst), .bank(host_bank), .addr(host_addr),
    .wr(host_wr), .wdata(host_wdata), .fast_en(fast_en)
  );

  fra_access_decode #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_decode (
    .bank(host_bank), .addr(host_addr), .rd(host_rd), .dma(host_dma),
    .fast_rom_rd(fast_rom_rd)
  );

  // Registered pause and owner; mode used is the one before this cycle's write
  always_ff @(posedge clk) begin
    if (rst) begin
      cop_pause <= 1'b0;
      rom_owner <= OWNER_COP;
    end else if (fast_en && fast_rom_rd) begin
      cop_pause <= 1'b1;
      rom_owner <= OWNER_HOST;
    end else begin
      cop_pause <= 1'b0;
      rom_owner <= OWNER_COP;
    end
  end

  // R9: owner is one-hot and tracks the pause
  p_owner_match_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot(rom_owner) && (rom_owner[1] == cop_pause));
  // R7: DMA reads never pause
  p_dma_no_pause_r7: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_dma) |=> !cop_pause);
  // R6: low-bank reads never pause
  p_low_bank_r6: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_bank[BANK_W-1]) |=> !cop_pause);
  // R8: no pause when mode was off
  p_mode_off_r8: assert property (@(posedge clk) disable iff (rst)
    !fast_en |=> !cop_pause);
  // R9 / R11: no read strobe means pause released on the next edge
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !cop_pause);
endmodule

// File: tb/test_fast_rom_arbiter.sv
`timescale 1ns/1ps
module test_fast_rom_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  host_bank = '0;
  logic [15:0] host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0, host_dma = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic        cop_pause;
  logic [1:0]  rom_owner;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference state
  bit mdl_fast = 0;
  bit exp_pause = 0;

  always #2 clk = ~clk;

  fast_rom_arbiter i_fast_rom_arbiter (
    .clk(clk), .rst(rst), .host_bank(host_bank), .host_addr(host_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_dma(host_dma),
    .host_wdata(host_wdata), .cop_pause(cop_pause), .rom_owner(rom_owner)
  );

  function automatic bit is_fast_read(int b, int a, bit rd, bit dma);
    return rd && !dma && (b >= 'h80) && ((b >= 'hC0) || (a >= 'h8000));
  endfunction

  function automatic bit is_reg_write(int b, int a, bit wr);
    return wr && (a == 'h420D) && ((b < 'h40) || ((b >= 'h80) && (b < 'hC0)));
  endfunction

  // Reference model: update on each edge, compare shortly after it
  always @(posedge clk) begin
    bit nxt_pause;
    if (rst) begin
      nxt_pause = 0;
      mdl_fast = 0;
    end else begin
      nxt_pause = mdl_fast && is_fast_read(host_bank, host_addr, host_rd, host_dma);
      if (is_reg_write(host_bank, host_addr, host_wr)) mdl_fast = host_wdata[0];
    end
    exp_pause = nxt_pause;
    #1;
    compared++;
    if (cop_pause !== exp_pause || rom_owner !== (exp_pause ? 2'b10 : 2'b01)) begin
      mismatched++;
      $display("FAIL %s t=%0t: pause=%b owner=%b expected pause=%b owner=%b",
               tag, $time, cop_pause, rom_owner, exp_pause,
               exp_pause ? 2'b10 : 2'b01);
    end
  end

  task automatic drive(input string t, input int b, input int a, input bit rd,
                       input bit wr, input bit dma, input int d, input int n);
    @(negedge clk);
    tag = t;
    host_bank = b[7:0]; host_addr = a[15:0];
    host_rd = rd; host_wr = wr; host_dma = dma; host_wdata = d[7:0];
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic idle(input string t, input int n);
    drive(t, 0, 0, 0, 0, 0, 0, n);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle("R1", 2);
    // R8: mode off, fast-bank read ignored
    drive("R8", 'hC0, 'h1234, 1, 0, 0, 0, 3);
    drive("R8", 'h80, 'h8000, 1, 0, 0, 0, 2);
    // R2: only bit 0 counts
    drive("R2", 'h00, 'h420D, 0, 1, 0, 'hFE, 1);
    drive("R2", 'hC0, 'h0000, 1, 0, 0, 0, 2);
    drive("R2", 'h00, 'h420D, 0, 1, 0, 'h01, 1);
    idle("R2", 1);
    // R5: whole-bank ROM region
    drive("R5", 'hC5, 'h0010, 1, 0, 0, 0, 3);
    drive("R5", 'hFF, 'hFFFF, 1, 0, 0, 0, 2);
    // R9: single-cycle read, rise and fall edges
    idle("R9", 1);
    drive("R9", 'h80, 'h8000, 1, 0, 0, 0, 1);
    idle("R9", 2);
    // R4: ROM window of the fast mirror banks
    drive("R4", 'h9F, 'hFFFF, 1, 0, 0, 0, 2);
    // R10: below the ROM window
    drive("R10", 'h85, 'h1000, 1, 0, 0, 0, 2);
    drive("R10", 'hBF, 'h7FFF, 1, 0, 0, 0, 1);
    // R6: low banks
    drive("R6", 'h00, 'h8000, 1, 0, 0, 0, 2);
    drive("R6", 'h40, 'h0000, 1, 0, 0, 0, 1);
    drive("R6", 'h7F, 'hFFFF, 1, 0, 0, 0, 1);
    // R7: DMA reads
    drive("R7", 'hC0, 'h0000, 1, 0, 1, 0, 2);
    drive("R7", 'h80, 'h8000, 1, 0, 1, 0, 2);
    // R11: writes to ROM space
    drive("R11", 'hC0, 'h0000, 0, 1, 0, 'h55, 2);
    // R3: misses of the register leave mode on
    drive("R3", 'h40, 'h420D, 0, 1, 0, 'h00, 1);
    drive("R3", 'hC0, 'h420D, 0, 1, 0, 'h00, 1);
    drive("R3", 'h00, 'h420C, 0, 1, 0, 'h00, 1);
    drive("R3", 'hC0, 'h0000, 1, 0, 0, 0, 2);
    // R9: back-to-back reads switching class
    drive("R9", 'hC1, 'h0000, 1, 0, 0, 0, 1);
    drive("R9", 'h01, 'h8000, 1, 0, 0, 0, 1);
    drive("R9", 'hC1, 'h0004, 1, 0, 0, 0, 1);
    // R2: mirror bank 0x80 turns mode off
    drive("R2", 'h80, 'h420D, 0, 1, 0, 'h00, 1);
    drive("R2", 'hC0, 'h0000, 1, 0, 0, 0, 2);
    // R1: reset mid-access clears mode
    drive("R2", 'h00, 'h420D, 0, 1, 0, 'h01, 1);
    drive("R1", 'hC0, 'h0000, 1, 0, 0, 0, 2);
    rst = 1'b1;
    idle("R1", 2);
    rst = 1'b0;
    drive("R1", 'hC0, 'h0000, 1, 0, 0, 0, 2);
    idle("R1", 2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule